// File: doc/BRIEF.md
# UART Register File with Interrupt Identification

This block is the processor-facing register bank of a 16550-style serial port. It has eight byte-wide registers, picked by a 3-bit offset. A host reads and writes them with single-cycle strobes. The read data is combinational on the current offset, and any side effect of a read takes place at the clock edge where `rd_en` is high.

Bit 7 of the line control register switches offsets 0 and 1 over to the two halves of a 16-bit baud divisor. The block does no bit-level serialisation and has no FIFO:
- A byte written for transmission is offered on a valid/ready output.
- A received byte arrives as a one-cycle pulse and raises data-ready.

Transmit, receive and modem events are combined into one interrupt line and a prioritised identification code. A hidden transmit-pending flag means the "holding register empty" interrupt is acknowledged by reading the identification register. A loopback mode feeds the modem control outputs back into the modem status read value.

Top module: `uart_regfile`

## Requirements
- R1: After reset, line status (offset 5) reads 0x60, identification (offset 2) reads 0x01, `irq` is low, `tx_valid` is low, and IER, LCR, MCR, scratch and divisor are zero.
- R2: Identification reads 0x04 when data-ready (LSR bit 0) and IER bit 0 are both set. Otherwise it reads 0x02 when the hidden transmit-pending flag and IER bit 1 are both set. Otherwise it reads 0x01.
- R3: `irq` is high exactly when bit 0 of the identification value is 0.
- R4: With LCR bit 7 clear, a write to offset 0 presents the byte on `tx_data` with `tx_valid` high from the next cycle. The same write clears LSR bits 5 and 6 and the pending flag. In the cycle after `tx_valid` and `tx_ready` are both high, `tx_valid` is low, LSR bits 6:5 read 11 and the pending flag is set, unless a new offset-0 write came in that cycle.
- R5: With LCR bit 7 set, offsets 0 and 1 read and write the divisor low and high bytes. They do not touch the transmitter or IER. `divisor` outputs the full value.
- R6: A read of offset 2 that returns 0x02 clears the pending flag, unless a transmit hand-off completes in the same cycle. A read that returns any other value leaves the flag unchanged.
- R7: An `rx_valid` pulse stores `rx_data` and sets LSR bit 0. A read of offset 0 with LCR bit 7 clear returns the stored byte and clears LSR bit 0, unless a new byte arrives in that same cycle.
- R8: While MCR bit 4 is set, offset 6 reads MCR bit 3 on bit 7, MCR bit 2 on bit 6, MCR bit 0 on bit 5 and MCR bit 1 on bit 4, with bits 3:0 zero.
- R9: While MCR bit 4 is clear, offset 6 reads the value `msr_in` had one cycle earlier.
- R10: Writes to offsets 2 and 5 have no effect. Offset 7 is a plain read/write scratch byte. Offset 3 reads back all 8 written bits, offset 4 reads back the low 5, and IER (offset 1, LCR bit 7 clear) reads back the low 4 with the upper bits zero.
- R11: `modem_ctl` equals MCR bits 3:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 3 | Register offset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe (triggers read side effects) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| tx_data | output | 8 | Byte to transmit |
| tx_valid | output | 1 | Transmit byte valid |
| tx_ready | input | 1 | Transmitter accepts byte |
| rx_data | input | 8 | Received byte |
| rx_valid | input | 1 | Received byte strobe |
| msr_in | input | 8 | Modem status inputs |
| modem_ctl | output | 4 | Modem control outputs |
| divisor | output | 16 | Baud divisor |
| irq | output | 1 | Interrupt request |

## Verification
Directed sequences cover the transmit-empty interrupt and its acknowledgement by an identification read. They also cover receive priority over transmit, with an identification read returning 0x04 that leaves the pending flag in place. The same sequences toggle the divisor latch and switch loopback on and off. A long random stretch then mixes reads, writes, receive pulses and `tx_ready` in every combination, so same-cycle collisions are exercised: a write colliding with a hand-off, receive with an offset-0 read, and an acknowledge with a hand-off. Every read value and `irq` is compared with a bench model, which separates a wrong precedence from a wrong register decode.

// File: rtl/uart_regfile.sv
module uart_regfile (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  addr,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [7:0]  wdata,
  output logic [7:0]  rdata,
  output logic [7:0]  tx_data,
  output logic        tx_valid,
  input  logic        tx_ready,
  input  logic [7:0]  rx_data,
  input  logic        rx_valid,
  input  logic [7:0]  msr_in,
  output logic [3:0]  modem_ctl,
  output logic [15:0] divisor,
  output logic        irq
);
  localparam logic [7:0] IIR_NONE = 8'h01;
  localparam logic [7:0] IIR_TX   = 8'h02;
  localparam logic [7:0] IIR_RX   = 8'h04;

  logic [7:0] rbr_q, thr_q, dll_q, dlm_q, lcr_q, scr_q, msr_q;
  logic [3:0] ier_q;
  logic [4:0] mcr_q;
  logic       dr_q, thre_q, temt_q, pend_q;
  logic [7:0] iir, lsr, msr_rd;
  logic       dlab, accept, wr_thr;

  assign dlab   = lcr_q[7];
  assign accept = tx_valid & tx_ready;
  assign wr_thr = wr_en & (addr == 3'd0) & ~dlab;

  assign iir = (dr_q & ier_q[0]) ? IIR_RX :
               (pend_q & ier_q[1]) ? IIR_TX : IIR_NONE;
  assign irq = ~iir[0];
  assign lsr = {1'b0, temt_q, thre_q, 4'b0, dr_q};
  assign msr_rd = mcr_q[4] ? {mcr_q[3], mcr_q[2], mcr_q[0], mcr_q[1], 4'b0} : msr_q;

  assign tx_data   = thr_q;
  assign modem_ctl = mcr_q[3:0];
  assign divisor   = {dlm_q, dll_q};

  always_comb begin
    case (addr)
      3'd0:    rdata = dlab ? dll_q : rbr_q;
      3'd1:    rdata = dlab ? dlm_q : {4'b0, ier_q};
      3'd2:    rdata = iir;
      3'd3:    rdata = lcr_q;
      3'd4:    rdata = {3'b0, mcr_q};
      3'd5:    rdata = lsr;
      3'd6:    rdata = msr_rd;
      default: rdata = scr_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rbr_q <= '0; thr_q <= '0; dll_q <= '0; dlm_q <= '0;
      lcr_q <= '0; scr_q <= '0; msr_q <= '0; ier_q <= '0; mcr_q <= '0;
      dr_q <= 1'b0; thre_q <= 1'b1; temt_q <= 1'b1; pend_q <= 1'b0;
      tx_valid <= 1'b0;
    end else begin
      msr_q <= msr_in;

      if (accept) begin
        tx_valid <= 1'b0;
        thre_q   <= 1'b1;
        temt_q   <= 1'b1;
        pend_q   <= 1'b1;
      end else if (rd_en && addr == 3'd2 && iir[2:0] == 3'd2) begin
        pend_q <= 1'b0;
      end

      if (wr_thr) begin
        thr_q    <= wdata;
        tx_valid <= 1'b1;
        thre_q   <= 1'b0;
        temt_q   <= 1'b0;
        pend_q   <= 1'b0;
      end

      if (wr_en) begin
        case (addr)
          3'd0: if (dlab) dll_q <= wdata;
          3'd1: if (dlab) dlm_q <= wdata; else ier_q <= wdata[3:0];
          3'd3: lcr_q <= wdata;
          3'd4: mcr_q <= wdata[4:0];
          3'd7: scr_q <= wdata;
          default: ;
        endcase
      end

      if (rd_en && addr == 3'd0 && !dlab) dr_q <= 1'b0;
      if (rx_valid) begin
        rbr_q <= rx_data;
        dr_q  <= 1'b1;
      end
    end
  end
endmodule

module uart_regfile_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] addr,
  input logic       wr_en,
  input logic       rd_en,
  input logic [7:0] rdata,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic       rx_valid,
  input logic       irq,
  input logic       dlab,
  input logic [3:0] ier,
  input logic [4:0] mcr,
  input logic [7:0] lsr,
  input logic [7:0] iir
);
  a_r2_masked_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (ier[1:0] == 2'b00) |-> !irq);

  a_r4_load: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd0 && !dlab) |=> (tx_valid && !lsr[5] && !lsr[6]));

  a_r4_handoff: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready && !(wr_en && addr == 3'd0 && !dlab)) |=> (!tx_valid && lsr[6:5] == 2'b11));

  a_r6_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 3'd2 && iir == 8'h02 && !(tx_valid && tx_ready)) |=> (iir != 8'h02));

  a_r7_rx_ready: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> lsr[0]);

  a_r8_loopback: assert property (@(posedge clk) disable iff (!rst_n)
    (mcr[4] && addr == 3'd6) |-> (rdata[3:0] == 4'h0 && rdata[7] == mcr[3] && rdata[5] == mcr[0]));
endmodule

bind uart_regfile uart_regfile_chk u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
  .rdata(rdata), .tx_valid(tx_valid), .tx_ready(tx_ready), .rx_valid(rx_valid),
  .irq(irq), .dlab(dlab), .ier(ier_q), .mcr(mcr_q), .lsr(lsr), .iir(iir)
);

// File: tb/uart_regfile_tb.sv
module uart_regfile_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] addr = '0;
  logic wr_en = 1'b0, rd_en = 1'b0, tx_ready = 1'b0, rx_valid = 1'b0;
  logic [7:0] wdata = '0, rx_data = '0, msr_in = '0;
  logic [7:0] rdata, tx_data;
  logic tx_valid, irq;
  logic [3:0] modem_ctl;
  logic [15:0] divisor;

  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  uart_regfile u_dut (.*);

  // bench model
  logic [7:0] m_rbr, m_thr, m_dll, m_dlm, m_lcr, m_scr, m_msr;
  logic [3:0] m_ier;
  logic [4:0] m_mcr;
  logic m_dr, m_thre, m_temt, m_pend, m_txv;

  function automatic logic [7:0] m_iir();
    if (m_dr && m_ier[0]) return 8'h04;
    if (m_pend && m_ier[1]) return 8'h02;
    return 8'h01;
  endfunction

  function automatic logic [7:0] m_read(input logic [2:0] a);
    case (a)
      3'd0: return m_lcr[7] ? m_dll : m_rbr;
      3'd1: return m_lcr[7] ? m_dlm : {4'h0, m_ier};
      3'd2: return m_iir();
      3'd3: return m_lcr;
      3'd4: return {3'b0, m_mcr};
      3'd5: return {1'b0, m_temt, m_thre, 4'h0, m_dr};
      3'd6: return m_mcr[4] ? {m_mcr[3], m_mcr[2], m_mcr[0], m_mcr[1], 4'h0} : m_msr;
      default: return m_scr;
    endcase
  endfunction

  function automatic string req_of(input logic [2:0] a);
    case (a)
      3'd0: return "R5/R7";
      3'd1: return "R5/R10";
      3'd2: return "R2/R6";
      3'd3: return "R10";
      3'd4: return "R10";
      3'd5: return "R4/R7";
      3'd6: return "R8/R9";
      default: return "R10";
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic m_reset();
    m_rbr = 0; m_thr = 0; m_dll = 0; m_dlm = 0; m_lcr = 0; m_scr = 0; m_msr = 0;
    m_ier = 0; m_mcr = 0; m_dr = 0; m_thre = 1; m_temt = 1; m_pend = 0; m_txv = 0;
  endtask

  task automatic m_update(input logic w, input logic r, input logic [2:0] a, input logic [7:0] d,
                          input logic rxv, input logic [7:0] rxd, input logic rdy, input logic [7:0] ms);
    logic dl;
    logic [7:0] iv;
    dl = m_lcr[7];
    iv = m_iir();
    m_msr = ms;
    if (m_txv && rdy) begin
      m_txv = 0; m_thre = 1; m_temt = 1; m_pend = 1;
    end else if (r && a == 3'd2 && iv == 8'h02) m_pend = 0;
    if (w) begin
      case (a)
        3'd0: if (dl) m_dll = d; else begin m_thr = d; m_txv = 1; m_thre = 0; m_temt = 0; m_pend = 0; end
        3'd1: if (dl) m_dlm = d; else m_ier = d[3:0];
        3'd3: m_lcr = d;
        3'd4: m_mcr = d[4:0];
        3'd7: m_scr = d;
        default: ;
      endcase
    end
    if (r && a == 3'd0 && !dl) m_dr = 0;
    if (rxv) begin m_rbr = rxd; m_dr = 1; end
  endtask

  // one cycle: drive after negedge, check before posedge, update model after
  task automatic step(input logic w, input logic r, input logic [2:0] a, input logic [7:0] d,
                      input logic rxv = 0, input logic [7:0] rxd = 0, input logic rdy = 0,
                      input logic [7:0] ms = 8'h00);
    wr_en = w; rd_en = r; addr = a; wdata = d; rx_valid = rxv; rx_data = rxd;
    tx_ready = rdy; msr_in = ms;
    #1;
    if (r) chk(req_of(a), {24'h0, rdata}, {24'h0, m_read(a)});
    chk("R3", {31'h0, irq}, {31'h0, ~m_iir() [0]});
    chk("R4", {31'h0, tx_valid}, {31'h0, m_txv});
    if (m_txv) chk("R4", {24'h0, tx_data}, {24'h0, m_thr});
    chk("R5", {16'h0, divisor}, {16'h0, m_dlm, m_dll});
    chk("R11", {28'h0, modem_ctl}, {28'h0, m_mcr[3:0]});
    @(posedge clk);
    m_update(w, r, a, d, rxv, rxd, rdy, ms);
    @(negedge clk);
  endtask

  task automatic rd_exp(input string req, input logic [2:0] a, input logic [7:0] exp);
    wr_en = 0; rd_en = 1; addr = a; rx_valid = 0; tx_ready = 0;
    #1;
    chk(req, {24'h0, rdata}, {24'h0, exp});
    @(posedge clk);
    m_update(0, 1, a, 8'h00, 0, 8'h00, 0, msr_in);
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    m_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    chk("R1", {31'h0, irq}, 32'h0);
    chk("R1", {31'h0, tx_valid}, 32'h0);
    chk("R1", {16'h0, divisor}, 32'h0);
    rd_exp("R1", 3'd5, 8'h60);
    rd_exp("R1", 3'd2, 8'h01);

    // R4 transmit with held-off ready, then hand-off
    step(1, 0, 3'd1, 8'h02);                 // IER: tx interrupt enable
    step(1, 0, 3'd0, 8'hA5);
    rd_exp("R4", 3'd5, 8'h00);
    chk("R4", {24'h0, tx_data}, 32'hA5);
    step(0, 0, 3'd0, 8'h00, 0, 8'h00, 1);    // hand-off
    rd_exp("R4", 3'd5, 8'h60);
    chk("R3", {31'h0, irq}, 32'h1);
    // R6 acknowledge by identification read
    rd_exp("R6", 3'd2, 8'h02);
    rd_exp("R6", 3'd2, 8'h01);
    chk("R3", {31'h0, irq}, 32'h0);

    // R2 receive priority; read of 0x04 keeps pending flag
    step(0, 0, 3'd0, 8'h00, 0, 8'h00, 0);
    step(1, 0, 3'd0, 8'h11);
    step(0, 0, 3'd0, 8'h00, 0, 8'h00, 1);
    step(1, 0, 3'd1, 8'h03);
    step(0, 0, 3'd0, 8'h00, 1, 8'h3C);
    rd_exp("R2", 3'd2, 8'h04);
    rd_exp("R7", 3'd0, 8'h3C);
    rd_exp("R7", 3'd5, 8'h60);
    rd_exp("R6", 3'd2, 8'h02);

    // R5 divisor latch
    step(1, 0, 3'd3, 8'h83);
    step(1, 0, 3'd0, 8'h34);
    step(1, 0, 3'd1, 8'h12);
    chk("R5", {16'h0, divisor}, 32'h1234);
    chk("R5", {31'h0, tx_valid}, 32'h0);
    step(1, 0, 3'd3, 8'h03);
    rd_exp("R5", 3'd1, 8'h03);

    // R8/R9 loopback and stored status
    step(1, 0, 3'd4, 8'h15, 0, 8'h00, 0, 8'h9A);
    rd_exp("R8", 3'd6, 8'h60);
    step(1, 0, 3'd4, 8'h1A, 0, 8'h00, 0, 8'h9A);
    rd_exp("R8", 3'd6, 8'h90);
    step(1, 0, 3'd4, 8'h00, 0, 8'h00, 0, 8'h9A);
    rd_exp("R9", 3'd6, 8'h9A);

    // R10 ignored writes and scratch
    step(1, 0, 3'd5, 8'h00);
    step(1, 0, 3'd2, 8'hFF);
    rd_exp("R10", 3'd5, 8'h60);
    step(1, 0, 3'd7, 8'h5A);
    rd_exp("R10", 3'd7, 8'h5A);

    // constrained random mix
    for (int i = 0; i < 4000; i++) begin
      logic [2:0] a;
      logic w, r, rxv, rdy;
      logic [7:0] d;
      a   = 3'($urandom_range(0, 7));
      w   = ($urandom_range(0, 99) < 35);
      r   = ($urandom_range(0, 99) < 50);
      rxv = ($urandom_range(0, 99) < 10);
      rdy = ($urandom_range(0, 99) < 40);
      d   = 8'($urandom);
      if (w && a == 3'd3 && $urandom_range(0, 3) != 0) d[7] = 1'b0;
      step(w, r, a, d, rxv, 8'($urandom), rdy, 8'($urandom));
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule